// File: doc/BRIEF.md
# Multi-register transfer sequencer

This block moves a selected group of registers between a sixteen-entry register file and memory. The file holds eight data registers and eight address registers. A 16-bit selection mask picks the registers. One start pulse carries the direction, the transfer size, an addressing-mode code, the number of the base address register, the mask and an already computed start address. The sequencer then issues one memory transaction for each selected register. Memory is reached through a valid/ready port. The register file is reached through a combinational read port and a single write port.

Mask bits are visited from bit 0 upwards. In a store, the bits map to registers in reverse. In a load, they map in natural order. The address moves by the transfer size, either downwards before each access (predecrement store) or upwards after it (all other cases). When the last register has moved, the block pulses done for one cycle. With it come the final address, a writeback request for the base register when the mode calls for one, and the transfer cycle cost. These results hold until the next start.

Register numbers on the register-file port are 0 to 7 for data registers D0 to D7 and 8 to 15 for address registers A0 to A7.

Top module: `reg_burst_seq`

## Requirements
- R1: With size_long_i = 0 each register moves as a 16-bit word and the address steps by 2; a stored word carries the register's low half in mem_wdata_o[15:0] with the upper half zero. With size_long_i = 1 the full 32 bits move and the address steps by 4.
- R2: In a store (load_i = 0) mask bit b selects register number 15-b (bit 0 is A7, bit 7 is A0, bit 8 is D7, bit 15 is D0). Registers go in ascending bit order with mem_we_o = 1, and the write data is that register's contents.
- R3: In a store with mode_i = 4 (predecrement) the address is lowered by the step before each write. At done, wb_en_o = 1, wb_reg_o = base_reg_i and final_addr_o equals the last address written.
- R4: In a store with any other mode the first write goes to addr_i and the address rises by the step after each write. At done, final_addr_o is the address after the last step and wb_en_o = 0.
- R5: In a load (load_i = 1) mask bit b selects register number b. Registers go in ascending bit order with mem_we_o = 0, the address rises after each read, and the read data is written into that register.
- R6: A load with mode_i = 3 (postincrement) raises wb_en_o at done with wb_reg_o = base_reg_i and final_addr_o = address after the last read; a load with any other mode leaves wb_en_o = 0.
- R7: A word load writes the 16-bit read value sign-extended to 32 bits.
- R8: cost_o at done equals 4 per transferred register for word size and 8 per register for long size.
- R9: Registers whose mask bit is clear take no memory transaction and are not written.
- R10: An all-zero mask raises done_o in the cycle after start with no memory transaction, wb_en_o = 0, cost_o = 0 and final_addr_o = addr_i.
- R11: A transaction with mem_ready_i low holds its address, write enable and register number unchanged, and a start pulse while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| size_long_i | input | 1 | 1 = 32-bit transfers, 0 = 16-bit |
| mode_i | input | 3 | Addressing-mode code (3 postincrement, 4 predecrement) |
| base_reg_i | input | 3 | Base address register number |
| mask_i | input | 16 | Register selection mask |
| addr_i | input | 32 | Start address |
| busy_o | output | 1 | Operation in progress |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| rf_addr_o | output | 4 | Register number for read and write |
| rf_rdata_i | input | 32 | Register read data (combinational) |
| rf_we_o | output | 1 | Register write enable |
| rf_wdata_o | output | 32 | Register write data |
| done_o | output | 1 | One-cycle completion pulse |
| final_addr_o | output | 32 | Final address, held after done |
| wb_en_o | output | 1 | Base register writeback request, with done |
| wb_reg_o | output | 3 | Base register number to write back |
| cost_o | output | 8 | Accumulated transfer cycle cost, held after done |

## Verification
The assertions check on every cycle that a stalled request stays stable. They also check that each accepted transaction adds the correct cost step. A register write may occur only on an accepted read, a writeback request only with done, and done only when no request is outstanding.

Only the bench scenarios can show the rest. These are the register order in each direction, the address sequence and final address of each mode, sign extension of loaded words, and the skipping of clear mask bits. They also cover the all-zero mask and a start pulse injected while a transfer is running. Memory ready is randomly withheld throughout.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} rbx_state_e;
  localparam logic [2:0] MODE_POSTINC = 3'd3;
  localparam logic [2:0] MODE_PREDEC  = 3'd4;
endpackage

// File: rtl/rbx_pick.sv
module rbx_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic          store_i,
  output logic          any_o,
  output logic [IW-1:0] bit_o,
  output logic [IW-1:0] reg_o
);
  always_comb begin
    bit_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) bit_o = IW'(i);
    end
  end

  assign any_o = |mask_i;
  // stores walk the file in reverse
  assign reg_o = store_i ? (IW'(N - 1) - bit_o) : bit_o;
endmodule

// File: rtl/rbx_addr.sv
module rbx_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic          long_i,
  input  logic          predec_i,
  output logic [AW-1:0] acc_o,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] step;
  assign step   = long_i ? AW'(4) : AW'(2);
  assign next_o = predec_i ? (cur_i - step) : (cur_i + step);
  assign acc_o  = predec_i ? next_o : cur_i;
endmodule

// File: rtl/reg_burst_seq.sv
module reg_burst_seq
  import rbx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 8,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG),
  localparam int BW  = RW - 1,
  localparam int HW  = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          load_i,
  input  logic          size_long_i,
  input  logic [2:0]    mode_i,
  input  logic [BW-1:0] base_reg_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [RW-1:0] rf_addr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          done_o,
  output logic [AW-1:0] final_addr_o,
  output logic          wb_en_o,
  output logic [BW-1:0] wb_reg_o,
  output logic [CW-1:0] cost_o
);
  rbx_state_e      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   cur_q;
  logic            load_q, long_q, predec_q, wb_q;
  logic [BW-1:0]   base_q;
  logic [CW-1:0]   cost_q;

  logic            any_sel;
  logic [RW-1:0]   sel_bit, sel_reg;
  logic [AW-1:0]   acc_addr, next_addr;
  logic            hs;
  logic [NREG-1:0] rem_next;
  logic [CW-1:0]   cost_inc;

  rbx_pick #(.N(NREG), .IW(RW)) u_pick (
    .mask_i (rem_q),
    .store_i(!load_q),
    .any_o  (any_sel),
    .bit_o  (sel_bit),
    .reg_o  (sel_reg)
  );

  rbx_addr #(.AW(AW)) u_addr (
    .cur_i   (cur_q),
    .long_i  (long_q),
    .predec_i(predec_q),
    .acc_o   (acc_addr),
    .next_o  (next_addr)
  );

  assign hs       = mem_valid_o && mem_ready_i;
  assign rem_next = rem_q & (rem_q - NREG'(1));
  assign cost_inc = long_q ? CW'(8) : CW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rem_q    <= '0;
      cur_q    <= '0;
      load_q   <= 1'b0;
      long_q   <= 1'b0;
      predec_q <= 1'b0;
      wb_q     <= 1'b0;
      base_q   <= '0;
      cost_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q    <= mask_i;
          cur_q    <= addr_i;
          load_q   <= load_i;
          long_q   <= size_long_i;
          predec_q <= !load_i && (mode_i == MODE_PREDEC);
          wb_q     <= (|mask_i) && (load_i ? (mode_i == MODE_POSTINC)
                                           : (mode_i == MODE_PREDEC));
          base_q   <= base_reg_i;
          cost_q   <= '0;
          state_q  <= (|mask_i) ? ST_XFER : ST_DONE;
        end
        ST_XFER: if (hs) begin
          rem_q  <= rem_next;
          cur_q  <= next_addr;
          cost_q <= cost_q + cost_inc;
          if (rem_next == '0) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != ST_IDLE;
  assign mem_valid_o  = (state_q == ST_XFER) && any_sel;
  assign mem_addr_o   = acc_addr;
  assign mem_we_o     = mem_valid_o && !load_q;
  assign mem_wdata_o  = long_q ? rf_rdata_i : {{(DW-HW){1'b0}}, rf_rdata_i[HW-1:0]};
  assign rf_addr_o    = (state_q == ST_XFER) ? sel_reg : '0;
  assign rf_we_o      = hs && load_q;
  assign rf_wdata_o   = long_q ? mem_rdata_i : {{(DW-HW){mem_rdata_i[HW-1]}}, mem_rdata_i[HW-1:0]};
  assign done_o       = state_q == ST_DONE;
  assign final_addr_o = cur_q;
  assign wb_en_o      = done_o && wb_q;
  assign wb_reg_o     = base_q;
  assign cost_o       = cost_q;

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(rf_addr_o));

  assert_cost_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> cost_o == CW'($past(cost_o) + (long_q ? CW'(8) : CW'(4))));

  assert_rf_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> mem_valid_o && mem_ready_i && !mem_we_o);

  assert_wb_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_valid_o);

  assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i |=> busy_o);
endmodule

// File: tb/reg_burst_seq_tb.sv
`timescale 1ns/1ps
module reg_burst_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, load_i = 1'b0, size_long_i = 1'b0;
  logic [2:0]  mode_i = '0, base_reg_i = '0;
  logic [15:0] mask_i = '0;
  logic [31:0] addr_i = '0;
  logic        busy_o, mem_valid_o, mem_we_o, rf_we_o, done_o, wb_en_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, rf_wdata_o, final_addr_o, rf_rdata_i;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  rf_addr_o;
  logic [2:0]  wb_reg_o;
  logic [7:0]  cost_o;

  logic [31:0] rf_model [16];
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) if (rf_we_o) rf_model[rf_addr_o] <= rf_wdata_o;
  assign rf_rdata_i = rf_model[rf_addr_o];

  reg_burst_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hA5C3_0F1E;
  endfunction

  task automatic run_op(input bit ld, input bit lng, input logic [2:0] md,
                        input logic [2:0] base, input logic [15:0] msk,
                        input logic [31:0] a0, input bit inject);
    logic [31:0] pre [16];
    logic [31:0] expv [16];
    logic [15:0] rem;
    logic [31:0] a, step, ea;
    int n, k, cyc, b, r;
    bit predec, wb, ok;
    for (int i = 0; i < 16; i++) begin
      rf_model[i] = $urandom;
      pre[i] = rf_model[i];
      expv[i] = rf_model[i];
    end
    n = $countones(msk);
    predec = !ld && md == 3'd4;
    wb = (n != 0) && (ld ? md == 3'd3 : md == 3'd4);
    step = lng ? 32'd4 : 32'd2;
    rem = msk; a = a0; k = 0;
    @(negedge clk_i);
    start_i = 1; load_i = ld; size_long_i = lng; mode_i = md;
    base_reg_i = base; mask_i = msk; addr_i = a0;
    @(negedge clk_i);
    start_i = 0;
    cyc = 0;
    while (1) begin
      if (done_o) begin
        chk(k == n, "R9 transaction count", k, n);
        chk(final_addr_o == a, ld ? "R5 final address" : (predec ? "R3 final address" : "R4 final address"), final_addr_o, a);
        chk(wb_en_o == wb, ld ? "R6 writeback" : (predec ? "R3 writeback" : "R4 no writeback"), wb_en_o, wb);
        if (wb) chk(wb_reg_o == base, "R6 writeback register", wb_reg_o, base);
        chk(cost_o == 8'(n * (lng ? 8 : 4)), "R8 cost", cost_o, n * (lng ? 8 : 4));
        if (n == 0) chk(final_addr_o == a0 && !wb_en_o && cost_o == 0, "R10 empty mask result", final_addr_o, a0);
        for (int i = 0; i < 16; i++)
          chk(rf_model[i] == expv[i], ld ? "R7 register contents after load" : "R9 registers untouched", rf_model[i], expv[i]);
        break;
      end
      if (n == 0) chk(cyc == 0 && !mem_valid_o, "R10 no traffic on empty mask", cyc, 0);
      start_i = inject && cyc == 2;
      if (start_i) begin mask_i = 16'hFFFF; load_i = ~ld; addr_i = 32'hDEAD_0000; end
      if (mem_valid_o) begin
        r = (($urandom % 4) != 0) ? 1 : 0;
        mem_ready_i = r[0];
        if (r != 0) begin
          if (k >= n || rem == 0) begin
            chk(0, "R9 extra transaction", k, n);
          end else begin
            b = 0;
            for (int i = 15; i >= 0; i--) if (rem[i]) b = i;
            rem[b] = 1'b0;
            if (predec) begin a = a - step; ea = a; end
            else begin ea = a; a = a + step; end
            chk(mem_addr_o == ea, ld ? "R5 address" : (predec ? "R3 address" : "R4 address"), mem_addr_o, ea);
            chk(mem_we_o == !ld, "R2 write enable", mem_we_o, !ld);
            if (ld) begin
              chk(rf_addr_o == 4'(b), "R5 register order", rf_addr_o, b);
              mem_rdata_i = mem_val(ea);
              expv[b] = lng ? mem_rdata_i : {{16{mem_rdata_i[15]}}, mem_rdata_i[15:0]};
            end else begin
              chk(rf_addr_o == 4'(15 - b), "R2 register order", rf_addr_o, 15 - b);
              ok = lng ? mem_wdata_o == pre[15 - b] : mem_wdata_o == {16'h0, pre[15 - b][15:0]};
              chk(ok, "R1 write data", mem_wdata_o, lng ? pre[15 - b] : {16'h0, pre[15 - b][15:0]});
            end
            k++;
          end
        end
      end else mem_ready_i = 0;
      @(negedge clk_i);
      cyc++;
      if (cyc > 400) begin chk(0, "R11 operation hung", cyc, 400); break; end
    end
    start_i = 0; mem_ready_i = 0;
    @(negedge clk_i);
    chk(!busy_o, "R11 idle after done", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_valid_o && !rf_we_o, "R11 reset state", {busy_o, done_o, mem_valid_o}, 0);
    rst_ni = 1;
    run_op(0, 0, 3'd4, 3'd7, 16'h0000, 32'h0000_1000, 0);
    run_op(1, 1, 3'd3, 3'd2, 16'h0000, 32'h0000_2000, 0);
    run_op(0, 1, 3'd4, 3'd7, 16'h8001, 32'h0000_3000, 0);
    run_op(0, 0, 3'd4, 3'd5, 16'hFFFF, 32'h0000_4000, 0);
    run_op(0, 1, 3'd2, 3'd1, 16'h00F0, 32'h0000_5000, 0);
    run_op(1, 0, 3'd3, 3'd4, 16'hFFFF, 32'h0000_6000, 0);
    run_op(1, 1, 3'd5, 3'd3, 16'h8101, 32'h0000_7000, 0);
    run_op(1, 0, 3'd7, 3'd0, 16'h0F0F, 32'h0000_8FFE, 1);
    run_op(0, 1, 3'd4, 3'd6, 16'h0A50, 32'h0001_0000, 1);
    for (int t = 0; t < 40; t++) begin
      logic [2:0] md;
      md = 3'($urandom_range(2, 7));
      run_op(1'($urandom), 1'($urandom), md, 3'($urandom), 16'($urandom),
             32'($urandom) & 32'h00FF_FFFC, t % 5 == 0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule